// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation entries from memory. A walk begins in a context table selected by a root pointer and a context number, then descends through as many as three levels of page tables. An entry of the leaf kind may stop the walk at any of those levels, so one entry maps a 16 MB region (level 1), a 256 KB region (level 2) or a 4 KB page (level 3). When the walk cannot finish, the block reports a fault code that holds the level and the cause.

A requester presents an address and a write flag and waits for a one-cycle response. The response carries the physical address, the final entry and the fault code. The walker reaches memory through a single-word port that uses a valid/ready handshake and never has more than one read in flight. Before it answers a successful walk, it writes the referenced and modified status bits back into the leaf entry whenever either bit has to change. When the enable input is low, no walk takes place and the address passes straight through.

Top module: `ptw_walker`

## Requirements
- R1: With `cfg_enable` low, an accepted request is answered in the next cycle with `rsp_paddr` equal to the zero-extended virtual address, `rsp_fault` = 0 and `rsp_pte` = 0, and no memory transaction is made.
- R2: The first read of a walk goes to (`cfg_root` << 4) + (`cfg_ctx` << 2).
- R3: Bits [1:0] of an entry give its kind: 0 invalid, 1 table descriptor, 2 leaf, 3 reserved. A descriptor sends the next read to ((entry & ~3) << 4) plus an index of VA[31:24]×4 at level 1, VA[23:18]×4 at level 2 and VA[17:12]×4 at level 3.
- R4: A leaf found at level L gives `rsp_paddr` = (entry[31:8] << 12) + offset, where the offset is VA[23:0] for L=1, VA[17:0] for L=2 and VA[11:0] for L=3, with `rsp_fault` = 0.
- R5: An invalid entry ends the walk with `rsp_fault` = (L << 8) | (1 << 2), where L is 0 for the context table and 1 to 3 for the table levels.
- R6: A reserved entry, a leaf in the context table, or a descriptor at level 3 ends the walk with `rsp_fault` = (L << 8) | (4 << 2).
- R7: If the leaf's referenced bit (bit 5) is clear, or the access is a write and its modified bit (bit 6) is clear, the block writes the entry back to the same address with bit 5 set (and bit 6 set for a write) before it responds. `rsp_pte` then carries the updated value.
- R8: A leaf that already has every bit the access needs is not written back.
- R9: `busy` is low after reset and goes high in the cycle after a request is accepted. It stays high through the single response cycle, and any request presented while `busy` is high is ignored.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold steady. No new memory request is raised while a read waits for its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Translation on; low passes addresses through |
| cfg_root | input | 32 | Context table pointer, in 16-byte units |
| cfg_ctx | input | CTX_W | Context number |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| busy | output | 1 | Walk in progress; new requests ignored |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write-back |
| mem_req_addr | output | 36 | Entry address |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 36 | Physical address |
| rsp_pte | output | 32 | Final entry (updated leaf or faulting entry) |
| rsp_fault | output | 10 | Fault code; 0 on success |

## Verification
A new request can arrive in the same cycle as the response strobe. Here the walker has to stay blind until the strobe has gone. The bench provokes this by holding a different request on the inputs for the whole walk, including the response cycle, and dropping it one cycle later. It then checks that the answer belongs to the first address, that `busy` falls and stays low, and that no further memory reads appear. A second overlap, a read answer that arrives while ready toggles, is covered by repeating a full walk with a stalling memory.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the page table walker.
// Assumes 32-bit entries and a 32-bit virtual / 36-bit physical space.
package ptw_pkg;
    localparam int ENT_W    = 32;
    localparam int VA_W     = 32;
    localparam int PA_W     = 36;
    localparam int FAULT_W  = 10;
    localparam int REF_BIT  = 5;
    localparam int MOD_BIT  = 6;

    typedef enum logic [1:0] {
        KIND_INVALID = 2'd0,
        KIND_TABLE   = 2'd1,
        KIND_LEAF    = 2'd2,
        KIND_RSVD    = 2'd3
    } ent_kind_e;

    typedef enum logic [1:0] {
        ACT_DESCEND = 2'd0,
        ACT_LEAF    = 2'd1,
        ACT_FAULT   = 2'd2
    } walk_act_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_WAIT, ST_WBACK, ST_DONE
    } walk_st_e;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_XLATE   = 3'd4;

    // Pack level and cause into the response fault word.
    function automatic logic [FAULT_W-1:0] mk_fault(input logic [1:0] lvl,
                                                    input logic [2:0] cause);
        return {lvl, 3'b000, cause, 2'b00};
    endfunction
endpackage

// File: rtl/ptw_entry_eval.sv
`timescale 1ns/1ps
// Classifies a fetched entry at a given level: descend, leaf or fault.
// Also forms the status-updated leaf and says whether it must be written.
// Assumes level 0 is the context table and level 3 the last table.
module ptw_entry_eval
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0] entry,
    input  logic [1:0]       level,
    input  logic             is_write,
    output walk_act_e        act,
    output logic [2:0]       cause,
    output logic             need_wb,
    output logic [ENT_W-1:0] upd_entry
);
    ent_kind_e kind;
    assign kind = ent_kind_e'(entry[1:0]);

    // Decide the walk step from the entry kind and the level.
    always_comb begin
        act   = ACT_FAULT;
        cause = FT_XLATE;
        unique case (kind)
            KIND_INVALID: cause = FT_INVALID;
            KIND_TABLE:   if (level != 2'd3) act = ACT_DESCEND;
            KIND_LEAF:    if (level != 2'd0) act = ACT_LEAF;
            default:      cause = FT_XLATE;
        endcase
    end

    // Set referenced always, modified on writes; flag a needed write-back.
    always_comb begin
        upd_entry          = entry;
        upd_entry[REF_BIT] = 1'b1;
        if (is_write) upd_entry[MOD_BIT] = 1'b1;
        need_wb = !entry[REF_BIT] || (is_write && !entry[MOD_BIT]);
    end
endmodule

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
// Forms table read addresses and the final physical address.
// step_level 0 selects the context slot; 1..3 index the next table from
// a descriptor. leaf_level 1..3 selects the offset width of a leaf.
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [31:0]      root_ptr,
    input  logic [CTX_W-1:0] ctx,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [29:0]      desc_hi,
    input  logic [1:0]       step_level,
    input  logic [23:0]      leaf_ppn,
    input  logic [1:0]       leaf_level,
    output logic [PA_W-1:0]  tbl_addr,
    output logic [PA_W-1:0]  leaf_paddr
);
    localparam int IDX1_W = 8;
    localparam int IDX_W  = 6;

    logic [PA_W-1:0] next_base;
    logic [PA_W-1:0] ctx_slot;
    assign next_base = {desc_hi, 6'b0};
    assign ctx_slot  = PA_W'({ctx, 2'b00});

    // Address of the entry read at the requested step.
    always_comb begin
        unique case (step_level)
            2'd0: tbl_addr = {root_ptr, 4'b0} + ctx_slot;
            2'd1: tbl_addr = next_base + PA_W'({vaddr[31 -: IDX1_W], 2'b00});
            2'd2: tbl_addr = next_base + PA_W'({vaddr[23 -: IDX_W], 2'b00});
            default: tbl_addr = next_base + PA_W'({vaddr[17 -: IDX_W], 2'b00});
        endcase
    end

    // Leaf base plus the in-region offset chosen by the leaf level.
    always_comb begin
        unique case (leaf_level)
            2'd1:    leaf_paddr = {leaf_ppn, 12'b0} + PA_W'(vaddr[23:0]);
            2'd2:    leaf_paddr = {leaf_ppn, 12'b0} + PA_W'(vaddr[17:0]);
            default: leaf_paddr = {leaf_ppn, 12'b0} + PA_W'(vaddr[11:0]);
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
// Page table walker top: accepts one request at a time, walks the
// context table and up to three table levels, writes back status bits
// on the leaf when needed, and returns a one-cycle response.
// Assumes memory answers each accepted read exactly once.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [31:0]      cfg_root,
    input  logic [CTX_W-1:0] cfg_ctx,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic [ENT_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_rdata,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [ENT_W-1:0] rsp_pte,
    output logic [FAULT_W-1:0] rsp_fault
);
    walk_st_e          st;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [1:0]        lvl_q;
    logic [PA_W-1:0]   addr_q;
    logic [PA_W-1:0]   paddr_q;
    logic [ENT_W-1:0]  pte_q;
    logic [FAULT_W-1:0] fault_q;

    walk_act_e         act;
    logic [2:0]        cause;
    logic              need_wb;
    logic [ENT_W-1:0]  upd_entry;
    logic [1:0]        step_level;
    logic [PA_W-1:0]   tbl_addr;
    logic [PA_W-1:0]   leaf_paddr;

    // Context slot while idle, otherwise the level below the current one.
    assign step_level = (st == ST_IDLE) ? 2'd0 : lvl_q + 2'd1;

    ptw_entry_eval u_eval (
        .entry     (mem_rsp_rdata),
        .level     (lvl_q),
        .is_write  (wr_q),
        .act       (act),
        .cause     (cause),
        .need_wb   (need_wb),
        .upd_entry (upd_entry)
    );

    ptw_addr_gen #(.CTX_W(CTX_W)) u_addr (
        .root_ptr   (cfg_root),
        .ctx        (cfg_ctx),
        .vaddr      (va_q),
        .desc_hi    (mem_rsp_rdata[31:2]),
        .step_level (step_level),
        .leaf_ppn   (mem_rsp_rdata[31:8]),
        .leaf_level (lvl_q),
        .tbl_addr   (tbl_addr),
        .leaf_paddr (leaf_paddr)
    );

    // Walk sequencer and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            lvl_q   <= 2'd0;
            addr_q  <= '0;
            paddr_q <= '0;
            pte_q   <= '0;
            fault_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    va_q <= req_vaddr;
                    wr_q <= req_write;
                    if (cfg_enable) begin
                        lvl_q  <= 2'd0;
                        addr_q <= tbl_addr;
                        st     <= ST_READ;
                    end else begin
                        paddr_q <= PA_W'(req_vaddr);
                        pte_q   <= '0;
                        fault_q <= '0;
                        st      <= ST_DONE;
                    end
                end
                ST_READ: if (mem_req_ready) st <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    unique case (act)
                        ACT_DESCEND: begin
                            lvl_q  <= lvl_q + 2'd1;
                            addr_q <= tbl_addr;
                            st     <= ST_READ;
                        end
                        ACT_LEAF: begin
                            paddr_q <= leaf_paddr;
                            pte_q   <= upd_entry;
                            fault_q <= '0;
                            st      <= need_wb ? ST_WBACK : ST_DONE;
                        end
                        default: begin
                            paddr_q <= '0;
                            pte_q   <= mem_rsp_rdata;
                            fault_q <= mk_fault(lvl_q, cause);
                            st      <= ST_DONE;
                        end
                    endcase
                end
                ST_WBACK: if (mem_req_ready) st <= ST_DONE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port drives derived from the state and held registers.
    assign busy          = (st != ST_IDLE);
    assign mem_req_valid = (st == ST_READ) || (st == ST_WBACK);
    assign mem_req_write = (st == ST_WBACK);
    assign mem_req_addr  = addr_q;
    assign mem_req_wdata = pte_q;
    assign rsp_valid     = (st == ST_DONE);
    assign rsp_paddr     = paddr_q;
    assign rsp_pte       = pte_q;
    assign rsp_fault     = fault_q;
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
// Protocol and response checks for ptw_walker, attached by bind.
module ptw_walker_chk
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             busy,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic             mem_req_write,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic [ENT_W-1:0] mem_req_wdata,
    input logic             mem_rsp_valid,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [FAULT_W-1:0] rsp_fault
);
    // Tracks a read accepted by memory whose data has not yet returned.
    logic rd_open;
    always_ff @(posedge clk) begin
        if (!rst_n) rd_open <= 1'b0;
        else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_open <= 1'b1;
        else if (mem_rsp_valid) rd_open <= 1'b0;
    end

    // R1
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !cfg_enable) |=>
            (rsp_valid && rsp_paddr == PA_W'($past(req_vaddr)) && rsp_fault == '0));

    // R5
    fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != '0) |->
            ((rsp_fault[4:2] == FT_INVALID || rsp_fault[4:2] == FT_XLATE)
             && rsp_fault[7:5] == 3'b0 && rsp_fault[1:0] == 2'b0));

    // R7
    wb_sets_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[REF_BIT]);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    // R10
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_open |-> !mem_req_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_enable    (cfg_enable),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
// Directed bench for ptw_walker with a behavioural entry memory.
module sim_ptw_walker;
    localparam int CTX_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b1;
    logic [31:0] cfg_root = 32'h100;
    logic [CTX_W-1:0] cfg_ctx = 8'd3;
    logic req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic req_write = 1'b0;
    logic busy;
    logic mem_req_valid, mem_req_write;
    logic mem_req_ready = 1'b0;
    logic [35:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic rsp_valid;
    logic [35:0] rsp_paddr;
    logic [31:0] rsp_pte;
    logic [9:0] rsp_fault;

    ptw_walker #(.CTX_W(CTX_W)) u0 (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Behavioural memory
    logic [31:0] mem [logic [35:0]];
    logic stall_mode = 1'b0;
    int lat = 0;
    logic pend = 1'b0;
    int pend_cnt = 0;
    logic [35:0] pend_addr = '0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [35:0] rd_log [8];
    logic [35:0] wr_addr = '0;
    logic [31:0] wr_data = '0;

    function automatic logic [31:0] rd_mem(input logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= rd_mem(pend_addr);
                pend <= 1'b0;
            end else pend_cnt <= pend_cnt - 1;
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt  <= wr_cnt + 1;
                wr_addr <= mem_req_addr;
                wr_data <= mem_req_wdata;
            end else begin
                pend      <= 1'b1;
                pend_cnt  <= lat;
                pend_addr <= mem_req_addr;
                rd_log[rd_cnt % 8] <= mem_req_addr;
                rd_cnt    <= rd_cnt + 1;
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            $display("FAIL watchdog: actual=%0d cycles expected<=50000", cyc);
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            summary();
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    logic [35:0] o_pa;
    logic [31:0] o_pte;
    logic [9:0]  o_flt;
    int rd0, wr0;

    // Issue one request and wait for its response.
    task automatic walk(input logic [31:0] va, input logic wr);
        int n;
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 500) begin @(negedge clk); n++; end
        chk("R9 response arrives", {63'b0, rsp_valid}, 64'd1);
        o_pa = rsp_paddr; o_pte = rsp_pte; o_flt = rsp_fault;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 reset busy", {63'b0, busy}, 0);
        chk("R9 reset rsp_valid", {63'b0, rsp_valid}, 0);
        chk("R10 reset mem_req_valid", {63'b0, mem_req_valid}, 0);
    endtask

    task automatic t_bypass();
        cfg_enable = 1'b0;
        walk(32'hDEADB123, 1'b0);
        chk("R1 bypass paddr", 64'(o_pa), 64'h0DEADB123);
        chk("R1 bypass fault", 64'(o_flt), 0);
        chk("R1 bypass pte", 64'(o_pte), 0);
        chk("R1 bypass no reads", 64'(rd_cnt - rd0), 0);
        cfg_enable = 1'b1;
    endtask

    task automatic t_l3_walk(input string tag);
        walk(32'h12345678, 1'b0);
        chk({tag, " R2 ctx slot addr"}, 64'(rd_log[rd0 % 8]), 64'h100C);
        chk({tag, " R3 level1 addr"}, 64'(rd_log[(rd0 + 1) % 8]), 64'h2048);
        chk({tag, " R3 level2 addr"}, 64'(rd_log[(rd0 + 2) % 8]), 64'h3034);
        chk({tag, " R3 level3 addr"}, 64'(rd_log[(rd0 + 3) % 8]), 64'h4014);
        chk({tag, " R4 4KB paddr"}, 64'(o_pa), 64'hABCDE0678);
        chk({tag, " R4 fault"}, 64'(o_flt), 0);
        chk({tag, " R8 no write-back"}, 64'(wr_cnt - wr0), 0);
    endtask

    task automatic t_big_pages();
        walk(32'h20ABCDEF, 1'b0);
        chk("R4 16MB paddr", 64'(o_pa), 64'h123ABCDEF);
        chk("R4 16MB reads", 64'(rd_cnt - rd0), 2);
        walk(32'h12FC1234, 1'b0);
        chk("R4 256KB paddr", 64'(o_pa), 64'h555001234);
        chk("R3 256KB level2 addr", 64'(rd_log[(rd0 + 2) % 8]), 64'h30FC);
    endtask

    task automatic t_writeback();
        mem[36'h4014] = 32'hABCDE002;
        walk(32'h12345678, 1'b0);
        chk("R7 read wb count", 64'(wr_cnt - wr0), 1);
        chk("R7 read wb addr", 64'(wr_addr), 64'h4014);
        chk("R7 read wb data", 64'(wr_data), 64'hABCDE022);
        chk("R7 read rsp_pte", 64'(o_pte), 64'hABCDE022);
        walk(32'h12345678, 1'b0);
        chk("R8 read after ref set", 64'(wr_cnt - wr0), 0);
        walk(32'h12345678, 1'b1);
        chk("R7 write wb count", 64'(wr_cnt - wr0), 1);
        chk("R7 write wb data", 64'(wr_data), 64'hABCDE062);
        chk("R7 write paddr", 64'(o_pa), 64'hABCDE0678);
        walk(32'h12345678, 1'b1);
        chk("R8 write after mod set", 64'(wr_cnt - wr0), 0);
    endtask

    task automatic t_faults();
        cfg_ctx = 8'd5;
        walk(32'h12345678, 1'b0);
        chk("R5 invalid ctx entry", 64'(o_flt), 64'h004);
        cfg_ctx = 8'd3;
        walk(32'h12040000, 1'b0);
        chk("R5 invalid level2", 64'(o_flt), 64'h204);
        chk("R5 no write-back", 64'(wr_cnt - wr0), 0);
        walk(32'h30000000, 1'b0);
        chk("R6 reserved level1", 64'(o_flt), 64'h110);
        cfg_ctx = 8'd6;
        walk(32'h12345678, 1'b0);
        chk("R6 leaf in ctx table", 64'(o_flt), 64'h010);
        cfg_ctx = 8'd3;
        walk(32'h12346000, 1'b0);
        chk("R6 descriptor at level3", 64'(o_flt), 64'h310);
        chk("R6 faulting entry", 64'(o_pte), 64'h501);
    endtask

    task automatic t_stall();
        stall_mode = 1'b1; lat = 3;
        t_l3_walk("stall");
        stall_mode = 1'b0; lat = 0;
    endtask

    // A second request is held on the inputs through the response cycle.
    task automatic t_overlap();
        int n;
        rd0 = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h20ABCDEF; req_write = 1'b0;
        @(negedge clk);
        req_vaddr = 32'h12345678;
        n = 0;
        while (!rsp_valid && n < 500) begin @(negedge clk); n++; end
        o_pa = rsp_paddr;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 overlap paddr of first", 64'(o_pa), 64'h123ABCDEF);
        chk("R9 busy after response", {63'b0, busy}, 0);
        repeat (6) @(negedge clk);
        chk("R9 held request ignored", 64'(rd_cnt - rd0), 2);
        chk("R9 stays idle", {63'b0, busy}, 0);
    endtask

    initial begin
        mem[36'h100C] = 32'h00000201;
        mem[36'h2048] = 32'h00000301;
        mem[36'h3034] = 32'h00000401;
        mem[36'h4014] = 32'hABCDE062;
        mem[36'h2080] = 32'h12300062;
        mem[36'h30FC] = 32'h55500062;
        mem[36'h20C0] = 32'h00000003;
        mem[36'h1018] = 32'h00000002;
        mem[36'h4018] = 32'h00000501;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_l3_walk("base");
        t_big_pages();
        t_writeback();
        t_faults();
        t_stall();
        t_overlap();
        summary();
    end
endmodule